// File: doc/BRIEF.md
# Floating-Point Condition Branch and Move Resolver

This block settles, in a single registered step, what a floating-point conditional branch or a conditional move does with the condition-code bits. A decode stage presents one instruction at a time with a valid strobe. The inputs are the operation kind, a five-bit selector field, a signed 16-bit word offset, the program counter of the instruction, a flag that marks it as sitting in a branch delay slot, the eight condition-code bits and one general-register value. One cycle later, with a matching valid strobe, the block reports whether a branch is taken, the next program counter, whether the delay slot must be annulled, whether a move may write its destination, and whether the instruction is illegal.

The selector field packs two things into five bits: a condition-code index in its upper three bits, and a sense in its lower two bits. Bit 0 picks "on true" or "on false". Bit 1 picks the likely form for branches. Likely branches annul their delay slot only when they fall through. Executing the delay-slot instruction and fetching instructions are handled outside this block.

Top module: `fpcb_resolver`

## Requirements
- R1: While reset is asserted, and after it until the first strobe, `out_valid`, `br_taken`, `slot_nullify`, `move_en`, `illegal` and `next_pc` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. When `in_valid` is low, every result output keeps its previous value.
- R3: For a branch (`op_kind` = 0), the condition bit is `cc_bits[sel_field[4:2]]`. If `sel_field[0]` = 1 the branch is taken when that bit is 1, and if `sel_field[0]` = 0 it is taken when that bit is 0.
- R4: A taken branch gives `next_pc` = `br_pc` + 4 + (sign-extended `br_offset` shifted left by 2), with `slot_nullify` = 0.
- R5: An ordinary branch (`sel_field[1]` = 0) that is not taken gives `next_pc` = `br_pc` + 4 and `slot_nullify` = 0.
- R6: A likely branch (`sel_field[1]` = 1) that is not taken gives `next_pc` = `br_pc` + 8 and `slot_nullify` = 1.
- R7: A branch with `in_delay_slot` = 1 gives `illegal` = 1, `br_taken` = 0, `slot_nullify` = 0, `move_en` = 0 and `next_pc` = `br_pc`, whatever the condition bits hold.
- R8: For a move on condition (`op_kind` = 1), `move_en` = 1 exactly when `cc_bits[sel_field[4:2]]` equals `sel_field[0]`. `sel_field[1]` and `in_delay_slot` have no effect on it.
- R9: For a move on zero (`op_kind` = 2), `move_en` = 1 exactly when `gpr_value` is zero. For a move on nonzero (`op_kind` = 3), it is 1 exactly when `gpr_value` is nonzero.
- R10: Every move gives `br_taken` = 0, `slot_nullify` = 0, `illegal` = 0 and `next_pc` = `br_pc` + 4. A branch always gives `move_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_kind | input | 2 | 0 branch, 1 move on condition, 2 move on zero, 3 move on nonzero |
| sel_field | input | 5 | [4:2] condition index, [1] likely, [0] sense |
| br_offset | input | 16 | Signed word offset of the branch |
| br_pc | input | 32 | Address of the instruction |
| in_delay_slot | input | 1 | Instruction sits in a branch delay slot |
| cc_bits | input | 8 | Condition-code bits |
| gpr_value | input | 32 | Register tested by zero/nonzero moves |
| out_valid | output | 1 | Results valid |
| br_taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next program counter |
| slot_nullify | output | 1 | Annul the delay-slot instruction |
| move_en | output | 1 | Conditional move may write |
| illegal | output | 1 | Branch in a delay slot |

## Verification
Every result passes through a single register stage. A wrong condition index or a wrong sense therefore shows on `br_taken` or `move_en` in the cycle right after the strobe. A broken offset path or a wrong likely decode shows on `next_pc` at that same edge. A hold-enable fault appears one cycle later, when a cycle without a strobe changes a result. The condition index is swept over all eight codes with a one-hot pattern, and again with the inverse pattern, so that a stuck or swapped select line shows on a named code.

// File: rtl/fpcb_pkg.sv
package fpcb_pkg;

  typedef enum logic [1:0] {
    OP_BRANCH       = 2'd0,
    OP_MOVE_CC      = 2'd1,
    OP_MOVE_ZERO    = 2'd2,
    OP_MOVE_NONZERO = 2'd3
  } fpcb_op_e;

  typedef struct packed {
    logic taken;
    logic nullify;
    logic move_en;
    logic illegal;
  } fpcb_flags_t;

  localparam int SENSE_BIT  = 0;
  localparam int LIKELY_BIT = 1;
  localparam int IDX_LSB    = 2;

  // A condition is met when the selected bit equals the wanted polarity.
  function automatic logic polarity_met(input logic bit_v, input logic want_true);
    return (bit_v == want_true);
  endfunction

endpackage

// File: rtl/fpcb_cond_sel.sv
module fpcb_cond_sel #(
  parameter int CC_COUNT = 8,
  localparam int IDX_W = (CC_COUNT > 1) ? $clog2(CC_COUNT) : 1
) (
  input  logic [CC_COUNT-1:0] cc_bits,
  input  logic [IDX_W-1:0]    cc_idx,
  input  logic                want_true,
  output logic                cc_bit,
  output logic                cond_met
);
  import fpcb_pkg::*;

  logic [CC_COUNT-1:0] hit;

  for (genvar g = 0; g < CC_COUNT; g++) begin : g_pick
    assign hit[g] = (cc_idx == IDX_W'(g)) & cc_bits[g];
  end

  assign cc_bit   = |hit;
  assign cond_met = polarity_met(cc_bit, want_true);

endmodule

// File: rtl/fpcb_pc_calc.sv
module fpcb_pc_calc #(
  parameter int PC_W        = 32,
  parameter int OFS_W       = 16,
  parameter int INSTR_BYTES = 4,
  localparam int SHIFT      = $clog2(INSTR_BYTES)
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  fall_pc,
  output logic [PC_W-1:0]  skip_pc,
  output logic [PC_W-1:0]  target_pc
);

  function automatic logic [PC_W-1:0] sext_words(input logic [OFS_W-1:0] w);
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-OFS_W){w[OFS_W-1]}}, w};
    return ext << SHIFT;
  endfunction

  function automatic logic [PC_W-1:0] step(input logic [PC_W-1:0] base, input int n);
    return base + PC_W'(n * INSTR_BYTES);
  endfunction

  assign fall_pc   = step(pc, 1);
  assign skip_pc   = step(pc, 2);
  assign target_pc = fall_pc + sext_words(ofs);

endmodule

// File: rtl/fpcb_decide.sv
module fpcb_decide #(
  parameter int PC_W = 32
) (
  input  fpcb_pkg::fpcb_op_e   op,
  input  logic                 likely,
  input  logic                 want_true,
  input  logic                 in_ds,
  input  logic                 cc_bit,
  input  logic                 cond_met,
  input  logic                 gpr_zero,
  input  logic [PC_W-1:0]      pc,
  input  logic [PC_W-1:0]      fall_pc,
  input  logic [PC_W-1:0]      skip_pc,
  input  logic [PC_W-1:0]      target_pc,
  output fpcb_pkg::fpcb_flags_t flags,
  output logic [PC_W-1:0]      npc
);
  import fpcb_pkg::*;

  always_comb begin
    flags = '0;
    npc   = fall_pc;
    unique case (op)
      OP_BRANCH: begin
        if (in_ds) begin
          flags.illegal = 1'b1;
          npc           = pc;
        end else if (cond_met) begin
          flags.taken = 1'b1;
          npc         = target_pc;
        end else if (likely) begin
          flags.nullify = 1'b1;
          npc           = skip_pc;
        end else begin
          npc = fall_pc;
        end
      end
      OP_MOVE_CC:      flags.move_en = polarity_met(cc_bit, want_true);
      OP_MOVE_ZERO:    flags.move_en = gpr_zero;
      OP_MOVE_NONZERO: flags.move_en = ~gpr_zero;
      default:         flags = '0;
    endcase
  end

endmodule

// File: rtl/fpcb_out_reg.sv
module fpcb_out_reg #(
  parameter int PC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  fpcb_pkg::fpcb_flags_t d_flags,
  input  logic [PC_W-1:0]       d_pc,
  output logic                  q_valid,
  output fpcb_pkg::fpcb_flags_t q_flags,
  output logic [PC_W-1:0]       q_pc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_flags <= '0;
      q_pc    <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_flags <= d_flags;
        q_pc    <= d_pc;
      end
    end
  end

endmodule

// File: rtl/fpcb_resolver.sv
module fpcb_resolver #(
  parameter int CC_COUNT    = 8,
  parameter int PC_W        = 32,
  parameter int OFS_W       = 16,
  parameter int GPR_W       = 32,
  parameter int INSTR_BYTES = 4,
  localparam int IDX_W      = (CC_COUNT > 1) ? $clog2(CC_COUNT) : 1,
  localparam int SEL_W      = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op_kind,
  input  logic [SEL_W-1:0]     sel_field,
  input  logic [OFS_W-1:0]     br_offset,
  input  logic [PC_W-1:0]      br_pc,
  input  logic                 in_delay_slot,
  input  logic [CC_COUNT-1:0]  cc_bits,
  input  logic [GPR_W-1:0]     gpr_value,
  output logic                 out_valid,
  output logic                 br_taken,
  output logic [PC_W-1:0]      next_pc,
  output logic                 slot_nullify,
  output logic                 move_en,
  output logic                 illegal
);
  import fpcb_pkg::*;

  fpcb_op_e        op;
  logic            want_true;
  logic            likely;
  logic [IDX_W-1:0] cc_idx;
  logic            cc_bit;
  logic            cond_met;
  logic            gpr_zero;
  logic [PC_W-1:0] fall_pc;
  logic [PC_W-1:0] skip_pc;
  logic [PC_W-1:0] target_pc;
  logic [PC_W-1:0] npc_d;
  fpcb_flags_t     flags_d;
  fpcb_flags_t     flags_q;

  assign op        = fpcb_op_e'(op_kind);
  assign want_true = sel_field[SENSE_BIT];
  assign likely    = sel_field[LIKELY_BIT];
  assign cc_idx    = sel_field[SEL_W-1:IDX_LSB];
  assign gpr_zero  = (gpr_value == '0);

  fpcb_cond_sel #(.CC_COUNT(CC_COUNT)) u_sel (
    .cc_bits   (cc_bits),
    .cc_idx    (cc_idx),
    .want_true (want_true),
    .cc_bit    (cc_bit),
    .cond_met  (cond_met)
  );

  fpcb_pc_calc #(.PC_W(PC_W), .OFS_W(OFS_W), .INSTR_BYTES(INSTR_BYTES)) u_pc (
    .pc        (br_pc),
    .ofs       (br_offset),
    .fall_pc   (fall_pc),
    .skip_pc   (skip_pc),
    .target_pc (target_pc)
  );

  fpcb_decide #(.PC_W(PC_W)) u_dec (
    .op        (op),
    .likely    (likely),
    .want_true (want_true),
    .in_ds     (in_delay_slot),
    .cc_bit    (cc_bit),
    .cond_met  (cond_met),
    .gpr_zero  (gpr_zero),
    .pc        (br_pc),
    .fall_pc   (fall_pc),
    .skip_pc   (skip_pc),
    .target_pc (target_pc),
    .flags     (flags_d),
    .npc       (npc_d)
  );

  fpcb_out_reg #(.PC_W(PC_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d_flags (flags_d),
    .d_pc    (npc_d),
    .q_valid (out_valid),
    .q_flags (flags_q),
    .q_pc    (next_pc)
  );

  assign br_taken     = flags_q.taken;
  assign slot_nullify = flags_q.nullify;
  assign move_en      = flags_q.move_en;
  assign illegal      = flags_q.illegal;

endmodule

// File: rtl/fpcb_resolver_chk.sv
module fpcb_resolver_chk #(
  parameter int PC_W  = 32,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       op_kind,
  input logic [SEL_W-1:0] sel_field,
  input logic             in_delay_slot,
  input logic [PC_W-1:0]  br_pc,
  input logic             cond_met,
  input logic             out_valid,
  input logic             br_taken,
  input logic [PC_W-1:0]  next_pc,
  input logic             slot_nullify,
  input logic             move_en,
  input logic             illegal
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_results_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(next_pc) && $stable(br_taken) && $stable(move_en)
                   && $stable(slot_nullify) && $stable(illegal)));

  assert_taken_tracks_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd0 && !in_delay_slot) |=> (br_taken == $past(cond_met)));

  assert_likely_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd0 && !in_delay_slot && sel_field[1] && !cond_met)
      |=> (slot_nullify && next_pc == $past(br_pc) + PC_W'(8)));

  assert_nullify_not_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(slot_nullify && br_taken));

  assert_ds_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd0 && in_delay_slot)
      |=> (illegal && !br_taken && !slot_nullify && !move_en));

  assert_move_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind != 2'd0)
      |=> (!br_taken && !illegal && !slot_nullify && next_pc == $past(br_pc) + PC_W'(4)));

  assert_branch_no_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'd0) |=> !move_en);

endmodule

bind fpcb_resolver fpcb_resolver_chk #(.PC_W(PC_W), .SEL_W(SEL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .op_kind       (op_kind),
  .sel_field     (sel_field),
  .in_delay_slot (in_delay_slot),
  .br_pc         (br_pc),
  .cond_met      (cond_met),
  .out_valid     (out_valid),
  .br_taken      (br_taken),
  .next_pc       (next_pc),
  .slot_nullify  (slot_nullify),
  .move_en       (move_en),
  .illegal       (illegal)
);

// File: tb/fpcb_resolver_bench.sv
module fpcb_resolver_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [4:0]  sel_field = '0;
  logic [15:0] br_offset = '0;
  logic [31:0] br_pc = '0;
  logic        in_delay_slot = 1'b0;
  logic [7:0]  cc_bits = '0;
  logic [31:0] gpr_value = '0;
  logic        out_valid, br_taken, slot_nullify, move_en, illegal;
  logic [31:0] next_pc;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fpcb_resolver u_fpcb_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .sel_field(sel_field), .br_offset(br_offset), .br_pc(br_pc),
    .in_delay_slot(in_delay_slot), .cc_bits(cc_bits), .gpr_value(gpr_value),
    .out_valid(out_valid), .br_taken(br_taken), .next_pc(next_pc),
    .slot_nullify(slot_nullify), .move_en(move_en), .illegal(illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Applies one instruction, computes the expected result from the requirements,
  // and checks the outputs in the cycle after the strobe.
  task automatic run_case(input string req, input logic [1:0] op, input logic [4:0] sel,
                          input logic [15:0] ofs, input logic [31:0] pc, input logic ds,
                          input logic [7:0] cc, input logic [31:0] gpr);
    logic bitv, t, nul, me, ill;
    logic [31:0] epc;
    bitv = cc[sel[4:2]];
    t = 0; nul = 0; me = 0; ill = 0; epc = pc + 32'd4;
    case (op)
      2'd0: begin
        if (ds) begin ill = 1; epc = pc; end
        else begin
          t = sel[0] ? bitv : ~bitv;
          if (t) epc = pc + 32'd4 + {{14{ofs[15]}}, ofs, 2'b00};
          else if (sel[1]) begin nul = 1; epc = pc + 32'd8; end
        end
      end
      2'd1: me = (bitv == sel[0]);
      2'd2: me = (gpr == 32'd0);
      default: me = (gpr != 32'd0);
    endcase
    @(negedge clk);
    op_kind = op; sel_field = sel; br_offset = ofs; br_pc = pc;
    in_delay_slot = ds; cc_bits = cc; gpr_value = gpr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "taken",     32'(br_taken), 32'(t));
    chk(req, "nullify",   32'(slot_nullify), 32'(nul));
    chk(req, "move_en",   32'(move_en), 32'(me));
    chk(req, "illegal",   32'(illegal), 32'(ill));
    chk(req, "next_pc",   next_pc, epc);
  endtask

  task automatic test_reset();
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "flags", 32'({br_taken, slot_nullify, move_en, illegal}), 0);
    chk("R1", "next_pc", next_pc, 0);
  endtask

  task automatic test_branch_basic();
    run_case("R3", 2'd0, 5'b000_00, 16'h0010, 32'h0000_1000, 0, 8'h00, 0); // false, cc0 clear
    run_case("R4", 2'd0, 5'b101_01, 16'hFFFC, 32'h0000_2000, 0, 8'h20, 0); // true, cc5 set, back
    run_case("R4", 2'd0, 5'b011_01, 16'h7FFF, 32'h0001_0000, 0, 8'h08, 0); // max forward
    run_case("R5", 2'd0, 5'b010_01, 16'h0040, 32'h0000_3000, 0, 8'hFB, 0); // true, cc2 clear
    run_case("R5", 2'd0, 5'b111_00, 16'h0040, 32'h0000_3100, 0, 8'h80, 0); // false, cc7 set
  endtask

  task automatic test_likely();
    run_case("R6", 2'd0, 5'b001_11, 16'h0020, 32'h0000_4000, 0, 8'h00, 0); // true likely, not taken
    run_case("R6", 2'd0, 5'b110_10, 16'h0020, 32'h0000_4100, 0, 8'h40, 0); // false likely, not taken
    run_case("R6", 2'd0, 5'b110_11, 16'h8000, 32'h0004_0000, 0, 8'h40, 0); // taken likely, no annul
  endtask

  task automatic test_delay_slot();
    run_case("R7", 2'd0, 5'b000_01, 16'h0010, 32'h0000_5000, 1, 8'h01, 0);
    run_case("R7", 2'd0, 5'b000_10, 16'h0010, 32'h0000_5004, 1, 8'h01, 0);
  endtask

  task automatic test_moves();
    run_case("R8", 2'd1, 5'b100_01, 16'h0, 32'h0000_6000, 0, 8'h10, 0);
    run_case("R8", 2'd1, 5'b100_00, 16'h0, 32'h0000_6004, 0, 8'h10, 0);
    run_case("R8", 2'd1, 5'b100_10, 16'h0, 32'h0000_6008, 1, 8'hEF, 0); // likely bit, ds ignored
    run_case("R9", 2'd2, 5'b000_00, 16'h0, 32'h0000_7000, 0, 8'hFF, 32'd0);
    run_case("R9", 2'd2, 5'b000_00, 16'h0, 32'h0000_7004, 0, 8'hFF, 32'h8000_0000);
    run_case("R9", 2'd3, 5'b000_01, 16'h0, 32'h0000_7008, 0, 8'h00, 32'h0000_0001);
    run_case("R10", 2'd3, 5'b000_01, 16'h0, 32'hFFFF_FFFC, 1, 8'h00, 32'd0);
  endtask

  task automatic test_index_sweep();
    for (int i = 0; i < 8; i++) begin
      run_case("R3", 2'd0, {i[2:0], 2'b01}, 16'h0004, 32'h0000_8000 + 32'(i*64), 0,
               8'(1 << i), 0);
      run_case("R3", 2'd0, {i[2:0], 2'b01}, 16'h0004, 32'h0000_9000 + 32'(i*64), 0,
               ~8'(1 << i), 0);
    end
  endtask

  task automatic test_hold();
    logic [31:0] held_pc;
    logic [3:0]  held_flags;
    run_case("R2", 2'd0, 5'b000_11, 16'h0001, 32'h0000_A000, 0, 8'h00, 0);
    held_pc = next_pc;
    held_flags = {br_taken, slot_nullify, move_en, illegal};
    @(negedge clk);
    op_kind = 2'd1; sel_field = 5'b000_01; cc_bits = 8'hFF; br_pc = 32'h1234_5678;
    @(negedge clk);
    chk("R2", "out_valid low", 32'(out_valid), 0);
    chk("R2", "next_pc held", next_pc, held_pc);
    chk("R2", "flags held", 32'({br_taken, slot_nullify, move_en, illegal}), 32'(held_flags));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_branch_basic();
    test_likely();
    test_delay_slot();
    test_moves();
    test_index_sweep();
    test_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule